// File: doc/BRIEF.md
# Receive DMA Request Channel Selector

This block raises the DMA request that asks a host DMA controller to move received frames out of a peripheral. It serves several request/acknowledge channel pairs, three by default. Software picks one channel by writing its index into a select register. Only that channel's request pin is driven. The request pins of the other channels stay undriven, so they can share board wiring with other bus agents.

The block samples a frames-pending level. When frames are waiting and the selection is valid, it raises the request and captures the current frame length in 16-bit words. It then counts the acknowledge strobes that the host returns on the active channel. An operation is complete when the count reaches that length. A burst-control level then decides what happens next. With burst off, the request drops after every operation. With burst on, the request stays high across frame boundaries for as long as more frames are pending.

No data passes through this block; the words themselves move on the host bus. For that reason there is no valid/ready stream interface here and no back-pressure to manage. Each acknowledge strobe means that one word has already been taken.

Top module: `rx_dma_chan_sel`

## Requirements
- R1: After reset, the select register holds the invalid index 3. All request outputs and all request enables are low.
- R2: A write with `cfg_we` high to address 0x024 loads `cfg_wdata[1:0]` as the channel index, and the upper data bits are ignored. A write to any other address leaves the selection unchanged.
- R3: Bit i of `dma_req_oe` is high only for the channel in use, and a low enable means that pin is high impedance. The channel in use is the latched channel while a request is active, and otherwise the select register. `dma_req` is never high where its enable is low. With index 3, no enable goes high and no request is ever raised.
- R4: While idle with a valid selection, `frames_pending` high at a clock edge makes the request on that channel high after that edge, and `frame_len` is latched at the same edge.
- R5: Each cycle in which the request is high and the active channel's `dma_ack` bit is high counts one 16-bit word. The operation completes on the ack that brings the count to the latched length, and a length of 0 completes on the first ack.
- R6: With `burst_en` low at the completing edge, the request is low after that edge. If frames are still pending, the request rises again one cycle later.
- R7: With `burst_en` high and `frames_pending` high at the completing edge, the request stays high and a new `frame_len` is latched at that edge. With `burst_en` high and nothing pending, the request drops.
- R8: Ack strobes on a channel other than the active one are ignored, and so are strobes that arrive while the request is low. They neither advance nor complete an operation.
- R9: A select write during an active request does not move the pins. The enable and the request stay on the latched channel until the operation completes, and the new selection applies from the next idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration write address |
| cfg_wdata | input | 16 | Configuration write data |
| burst_en | input | 1 | Burst control: keep the request up across frames |
| frames_pending | input | 1 | Received frames are waiting for transfer |
| frame_len | input | 11 | Length of the next frame in 16-bit words |
| dma_ack | input | 3 | Per-channel transfer acknowledge strobe |
| dma_req | output | 3 | Per-channel request value |
| dma_req_oe | output | 3 | Per-channel pad enable; low means high impedance |

## Verification
Suppose the word counter drifts or latches the wrong length. The request then drops some acks too early or too late, and that shows on `dma_req` in the cycle right after the wrong ack. Suppose instead the latched channel or the selection is corrupted. `dma_req_oe` then moves to another pin, or to no pin, at the next edge, and a stray ack would start to count. The bench sends acks on foreign channels and while the request is low, and it checks each cycle that the request neither drops nor rises out of turn.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } req_state_t;
endpackage

// File: rtl/rxdma_sel_reg.sv
module rxdma_sel_reg #(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 'h024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [SEL_W-1:0]  sel_q,
  output logic              sel_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '1;
    end else if (cfg_we && (cfg_addr == SEL_ADDR)) begin
      sel_q <= cfg_wdata[SEL_W-1:0];
    end
  end

  assign sel_valid = (sel_q < SEL_W'(NUM_CH));
endmodule

// File: rtl/rxdma_word_cnt.sv
module rxdma_word_cnt #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             hit,
  output logic             done
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt_q} + (LEN_W+1)'(1);
  assign done     = hit && (cnt_next >= {1'b0, len_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (start) begin
      cnt_q <= '0;
      len_q <= frame_len;
    end else if (done) begin
      cnt_q <= '0;
    end else if (hit) begin
      cnt_q <= cnt_next[LEN_W-1:0];
    end
  end

  // R5: the running count never reaches a nonzero latched length
  assert_cnt_below_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) |-> (cnt_q < len_q));
endmodule

// File: rtl/rxdma_pin_mux.sv
module rxdma_pin_mux #(
  parameter int NUM_CH = 3,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  active_ch,
  input  logic              active_valid,
  input  logic              req_on,
  input  logic [NUM_CH-1:0] ack_in,
  output logic              ack_sel,
  output logic [NUM_CH-1:0] dma_req,
  output logic [NUM_CH-1:0] dma_req_oe
);
  logic [NUM_CH-1:0] ack_hit;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic mine;
    assign mine          = active_valid && (active_ch == SEL_W'(i));
    assign dma_req_oe[i] = mine;
    assign dma_req[i]    = mine && req_on;
    assign ack_hit[i]    = mine && ack_in[i];
  end

  assign ack_sel = |ack_hit;

  assert_oe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dma_req_oe));
  assert_req_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req & ~dma_req_oe) == '0);
endmodule

// File: rtl/rx_dma_chan_sel.sv
module rx_dma_chan_sel
  import rxdma_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 11,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 'h024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              burst_en,
  input  logic              frames_pending,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [NUM_CH-1:0] dma_ack,
  output logic [NUM_CH-1:0] dma_req,
  output logic [NUM_CH-1:0] dma_req_oe
);
  localparam int SEL_W = $clog2(NUM_CH + 1);

  req_state_t       state_q;
  logic [SEL_W-1:0] ch_q;
  logic [SEL_W-1:0] sel_q;
  logic             sel_valid;
  logic [SEL_W-1:0] active_ch;
  logic             active_valid;
  logic             busy;
  logic             ack_sel;
  logic             hit;
  logic             done;
  logic             chain;
  logic             launch;
  logic             start;

  rxdma_sel_reg #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SEL_W(SEL_W), .SEL_ADDR(SEL_ADDR)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sel_q(sel_q), .sel_valid(sel_valid)
  );

  assign busy         = (state_q == ST_REQ);
  assign active_ch    = busy ? ch_q : sel_q;
  assign active_valid = busy || sel_valid;

  rxdma_pin_mux #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .active_ch(active_ch),
    .active_valid(active_valid), .req_on(busy), .ack_in(dma_ack),
    .ack_sel(ack_sel), .dma_req(dma_req), .dma_req_oe(dma_req_oe)
  );

  assign hit    = busy && ack_sel;
  assign launch = !busy && frames_pending && sel_valid;
  assign chain  = done && burst_en && frames_pending;
  assign start  = launch || chain;

  rxdma_word_cnt #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
    .hit(hit), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
    end else if (launch) begin
      state_q <= ST_REQ;
      ch_q    <= sel_q;
    end else if (done && !chain) begin
      state_q <= ST_IDLE;
    end
  end

  assert_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (dma_req != '0));
  assert_drop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !burst_en) |=> (dma_req == '0));
  assert_hold_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && burst_en && frames_pending) |=> (dma_req != '0));
  assert_invalid_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sel_valid) |-> (dma_req_oe == '0));
  assert_chan_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(dma_req_oe));
endmodule

// File: tb/rx_dma_chan_sel_tb.sv
module rx_dma_chan_sel_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        burst_en = 1'b0;
  logic        frames_pending = 1'b0;
  logic [10:0] frame_len = '0;
  logic [2:0]  dma_ack = '0;
  logic [2:0]  dma_req;
  logic [2:0]  dma_req_oe;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [2:0] oe;
    logic [2:0] req;
    string      tag;
  } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_dma_chan_sel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .burst_en(burst_en),
    .frames_pending(frames_pending), .frame_len(frame_len),
    .dma_ack(dma_ack), .dma_req(dma_req), .dma_req_oe(dma_req_oe)
  );

  task automatic cmp(input logic [2:0] eoe, input logic [2:0] ereq, input string tag);
    checks++;
    if (dma_req_oe !== eoe || dma_req !== ereq) begin
      errors++;
      $display("FAIL %s: oe=%b req=%b expected oe=%b req=%b",
               tag, dma_req_oe, dma_req, eoe, ereq);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        cmp(e.oe, e.req, e.tag);
      end
    end
  end

  task automatic cyc(input logic p, input logic b, input logic [2:0] ack,
                     input logic [10:0] len, input logic [2:0] eoe,
                     input logic [2:0] ereq, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_we = 1'b0;
    frames_pending = p;
    burst_en = b;
    dma_ack = ack;
    frame_len = len;
    e.oe = eoe; e.req = ereq; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d, input logic p,
                    input logic [2:0] eoe, input logic [2:0] ereq, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = a;
    cfg_wdata = d;
    frames_pending = p;
    dma_ack = '0;
    e.oe = eoe; e.req = ereq; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp(3'b000, 3'b000, "R1 reset state");
    rst_n = 1'b1;
    // invalid select after reset: no request even with frames pending
    cyc(1, 0, 3'b000, 11'd2, 3'b000, 3'b000, "R1 R3 invalid select quiet");
    cyc(1, 0, 3'b111, 11'd2, 3'b000, 3'b000, "R3 invalid select no request");
    // R2 write to another address has no effect
    wr(12'h030, 16'h0001, 0, 3'b000, 3'b000, "R2 other address ignored");
    // R2 upper bits ignored: select 1
    wr(12'h024, 16'hFFF1, 0, 3'b010, 3'b000, "R2 select channel 1");
    // R8 ack while idle ignored
    cyc(0, 0, 3'b010, 11'd3, 3'b010, 3'b000, "R8 ack while idle");
    // R4 rise, length 3 latched
    cyc(1, 0, 3'b000, 11'd3, 3'b010, 3'b010, "R4 request rises");
    cyc(1, 0, 3'b001, 11'd7, 3'b010, 3'b010, "R8 foreign ack ch0");
    cyc(1, 0, 3'b100, 11'd7, 3'b010, 3'b010, "R8 foreign ack ch2");
    cyc(1, 0, 3'b010, 11'd7, 3'b010, 3'b010, "R5 word 1 of 3");
    cyc(1, 0, 3'b010, 11'd7, 3'b010, 3'b010, "R5 word 2 of 3");
    cyc(1, 0, 3'b010, 11'd7, 3'b010, 3'b000, "R6 drop after word 3");
    cyc(1, 0, 3'b000, 11'd2, 3'b010, 3'b010, "R6 re-raise while pending");
    cyc(1, 0, 3'b010, 11'd5, 3'b010, 3'b010, "R5 word 1 of 2");
    cyc(0, 0, 3'b010, 11'd5, 3'b010, 3'b000, "R6 drop after word 2");
    cyc(0, 0, 3'b000, 11'd5, 3'b010, 3'b000, "R6 stays low when nothing pending");
    // R7 burst
    cyc(1, 1, 3'b000, 11'd2, 3'b010, 3'b010, "R7 burst request rises");
    cyc(1, 1, 3'b010, 11'd1, 3'b010, 3'b010, "R7 burst word 1 of 2");
    cyc(1, 1, 3'b010, 11'd1, 3'b010, 3'b010, "R7 burst holds across frame");
    cyc(0, 1, 3'b010, 11'd4, 3'b010, 3'b000, "R7 burst drops when none pending");
    cyc(0, 1, 3'b000, 11'd4, 3'b010, 3'b000, "R7 idle after burst");
    // R9 select change during active request
    cyc(1, 0, 3'b000, 11'd2, 3'b010, 3'b010, "R4 rise on channel 1");
    wr(12'h024, 16'h0002, 1, 3'b010, 3'b010, "R9 write while active holds pins");
    cyc(1, 0, 3'b100, 11'd2, 3'b010, 3'b010, "R9 R8 ack on new channel ignored");
    cyc(1, 0, 3'b010, 11'd2, 3'b010, 3'b010, "R9 word 1 on old channel");
    cyc(1, 0, 3'b010, 11'd2, 3'b100, 3'b000, "R9 new select after completion");
    cyc(1, 0, 3'b000, 11'd0, 3'b100, 3'b100, "R3 R4 request on channel 2");
    // R5 length 0 completes on first ack
    cyc(0, 0, 3'b100, 11'd0, 3'b100, 3'b000, "R5 zero length single ack");
    cyc(0, 0, 3'b000, 11'd0, 3'b100, 3'b000, "R5 idle after zero length");
    // back to invalid
    wr(12'h024, 16'h0003, 0, 3'b000, 3'b000, "R3 select 3 floats all");
    cyc(1, 0, 3'b000, 11'd2, 3'b000, 3'b000, "R3 select 3 never requests");
    cyc(1, 0, 3'b111, 11'd2, 3'b000, 3'b000, "R3 select 3 ack ignored");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule